// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block keeps the single reservation that makes a load-exclusive / store-exclusive pair behave as an atomic primitive for one processor. Each request names an operation (load-exclusive, store-exclusive, ordinary store or clear), a base address, an immediate offset and an access size. A load-exclusive records the effective address and size. A later store-exclusive is allowed to write memory only if it presents the same address and size and nothing has touched the reserved location in the meantime.

Writes by other bus masters arrive on a snoop input. Any snooped write that lands in the same aligned granule as the reservation cancels it. The monitor answers every store-exclusive with a done pulse and a fail bit, where 0 means the store was performed and 1 means it was refused. It also drives a write enable, the effective address and the size toward the memory port. Requests with a malformed offset or size code raise an illegal flag and are treated as failed accesses.

All outputs are registered and appear one clock after the request.

Top module: `excl_monitor`

## Requirements
- R1: Operation codes on req_op_i are 0 load-exclusive, 1 store-exclusive, 2 ordinary store and 3 clear. Size codes on req_size_i are 0 byte, 1 halfword and 2 word; code 3 is illegal.
- R2: For word accesses the effective address is base plus offset. For byte and halfword accesses the offset is ignored and the effective address is the base. mem_addr_o and mem_size_o report the effective address and the size one cycle after a request.
- R3: A store-exclusive passes only when a reservation is held, its effective address equals the reserved address and its size code equals the reserved size. A passing store-exclusive gives st_done_o=1, st_fail_o=0 and mem_we_o=1 in the cycle after the request.
- R4: A store-exclusive that does not pass gives st_done_o=1, st_fail_o=1 and mem_we_o=0 one cycle after the request. This covers an address mismatch, a size mismatch and the case where no reservation is held.
- R5: A snoop write whose address shares the 4-byte granule (address bits above bit 1) with the reservation cancels it. This applies in any cycle from the load-exclusive through the store-exclusive, including the store-exclusive's own cycle. A snoop hitting the new address in the same cycle as the load-exclusive leaves no reservation.
- R6: A legal ordinary store gives mem_we_o=1 and st_done_o=0 one cycle later. An ordinary store to the reserved granule cancels the reservation; one to any other granule leaves it intact.
- R7: Every store-exclusive, passing or failing, cancels the reservation. A new load-exclusive replaces any earlier reservation.
- R8: A clear operation cancels the reservation, so the next store-exclusive fails.
- R9: After reset no reservation is held, all outputs are 0, and a store-exclusive fails.
- R10: A request with size code 3, or a word request whose offset is not a multiple of 4 or exceeds 1020, raises illegal_o one cycle later and writes nothing. An illegal store-exclusive fails. An illegal load-exclusive leaves no reservation.
- R11: st_done_o pulses for exactly one cycle per store-exclusive and is 0 after every other operation and idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | Operation code |
| req_base_i | input | AW | Base address |
| req_offset_i | input | OW | Immediate offset (word accesses only) |
| req_size_i | input | 2 | Access size code |
| snoop_valid_i | input | 1 | Write by another master this cycle |
| snoop_addr_i | input | AW | Address of the snooped write |
| st_done_o | output | 1 | Store-exclusive completed (one-cycle pulse) |
| st_fail_o | output | 1 | Store-exclusive status: 0 performed, 1 refused |
| mem_we_o | output | 1 | Write enable to memory |
| mem_addr_o | output | AW | Effective address of the last request |
| mem_size_o | output | 2 | Size code of the last request |
| illegal_o | output | 1 | Last request was malformed |

## Verification
A snoop write and a store-exclusive, or a snoop write and a load-exclusive, can target the same granule in one clock cycle. The bench provokes both by raising snoop_valid_i in the very request cycle, with a snoop address swept across granules around the reserved word. It expects a refusal only for snoop addresses inside the reserved granule. In the load-exclusive case, the outcome is judged by whether the following store-exclusive passes. Idle-cycle snoops use the same sweep, so a decision made one cycle too late or in the wrong granule shows up as a status mismatch.

// File: rtl/exmon_pkg.sv
package exmon_pkg;
   localparam logic [1:0] OP_LDEX  = 2'd0;
   localparam logic [1:0] OP_STEX  = 2'd1;
   localparam logic [1:0] OP_STORE = 2'd2;
   localparam logic [1:0] OP_CLEAR = 2'd3;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;
   localparam logic [1:0] SZ_BAD  = 2'd3;
endpackage

// File: rtl/exmon_gran_cmp.sv
module exmon_gran_cmp #(
   parameter int AW        = 32,
   parameter int GRAN_LOG2 = 2
) (
   input  logic [AW-1:0] a_i,
   input  logic [AW-1:0] b_i,
   output logic          eq_o
);
   generate
      if (GRAN_LOG2 < 0 || GRAN_LOG2 >= AW) begin : g_bad_gran
         $error("exmon_gran_cmp: GRAN_LOG2 out of range");
      end
   endgenerate

   logic [AW-1:0] diff;
   assign diff = (a_i ^ b_i) >> GRAN_LOG2;
   assign eq_o = (diff == '0);
endmodule

// File: rtl/exmon_addr_gen.sv
module exmon_addr_gen
   import exmon_pkg::*;
#(
   parameter int AW         = 32,
   parameter int OW         = 11,
   parameter int OFF_MAX    = 1020,
   parameter int ALIGN_LOG2 = 2
) (
   input  logic [AW-1:0] base_i,
   input  logic [OW-1:0] offset_i,
   input  logic [1:0]    size_i,
   output logic [AW-1:0] eff_o,
   output logic          legal_o
);
   generate
      if (OW >= AW) begin : g_bad_ow
         $error("exmon_addr_gen: OW must be narrower than AW");
      end
      if (OFF_MAX >= (1 << OW)) begin : g_bad_max
         $error("exmon_addr_gen: OFF_MAX not representable in OW bits");
      end
   endgenerate

   localparam logic [OW-1:0] OFF_LIMIT = OW'(OFF_MAX);

   logic aligned;
   generate
      if (ALIGN_LOG2 == 0) begin : g_no_align
         assign aligned = 1'b1;
      end else begin : g_align
         assign aligned = (offset_i[ALIGN_LOG2-1:0] == '0);
      end
   endgenerate

   logic is_word, in_range;
   assign is_word  = (size_i == SZ_WORD);
   assign in_range = (offset_i <= OFF_LIMIT);

   always_comb begin
      if (is_word) eff_o = base_i + {{(AW-OW){1'b0}}, offset_i};
      else         eff_o = base_i;
   end

   assign legal_o = (size_i != SZ_BAD) && (!is_word || (aligned && in_range));
endmodule

// File: rtl/exmon_resv.sv
module exmon_resv #(
   parameter int AW        = 32,
   parameter int GRAN_LOG2 = 2
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          set_i,
   input  logic [AW-1:0] set_addr_i,
   input  logic [1:0]    set_size_i,
   input  logic          drop_i,
   input  logic          snoop_valid_i,
   input  logic [AW-1:0] snoop_addr_i,
   output logic          valid_o,
   output logic [AW-1:0] addr_o,
   output logic [1:0]    size_o,
   output logic          snoop_hit_o
);
   logic          valid_q;
   logic [AW-1:0] addr_q;
   logic [1:0]    size_q;
   logic          same_gran;

   exmon_gran_cmp #(.AW(AW), .GRAN_LOG2(GRAN_LOG2)) u_snoop_cmp (
      .a_i (snoop_addr_i),
      .b_i (addr_q),
      .eq_o(same_gran)
   );

   assign snoop_hit_o = valid_q && snoop_valid_i && same_gran;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
         size_q  <= '0;
      end else if (set_i) begin
         valid_q <= 1'b1;
         addr_q  <= set_addr_i;
         size_q  <= set_size_i;
      end else if (drop_i || snoop_hit_o) begin
         valid_q <= 1'b0;
      end
   end

   assign valid_o = valid_q;
   assign addr_o  = addr_q;
   assign size_o  = size_q;

   a_r7_drop_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drop_i && !set_i) |=> !valid_o);
   a_r5_snoop_cancels: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (snoop_hit_o && !set_i) |=> !valid_o);
   a_r9_reset_open: assert property (@(posedge clk_i)
      !rst_ni |=> !valid_o);
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
   import exmon_pkg::*;
#(
   parameter int AW         = 32,
   parameter int OW         = 11,
   parameter int OFF_MAX    = 1020,
   parameter int ALIGN_LOG2 = 2,
   parameter int GRAN_LOG2  = 2
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          req_valid_i,
   input  logic [1:0]    req_op_i,
   input  logic [AW-1:0] req_base_i,
   input  logic [OW-1:0] req_offset_i,
   input  logic [1:0]    req_size_i,
   input  logic          snoop_valid_i,
   input  logic [AW-1:0] snoop_addr_i,
   output logic          st_done_o,
   output logic          st_fail_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [1:0]    mem_size_o,
   output logic          illegal_o
);
   logic [AW-1:0] eff;
   logic          legal;

   exmon_addr_gen #(.AW(AW), .OW(OW), .OFF_MAX(OFF_MAX), .ALIGN_LOG2(ALIGN_LOG2)) u_addr (
      .base_i  (req_base_i),
      .offset_i(req_offset_i),
      .size_i  (req_size_i),
      .eff_o   (eff),
      .legal_o (legal)
   );

   logic is_ldex, is_stex, is_store, is_clear;
   assign is_ldex  = req_valid_i && (req_op_i == OP_LDEX);
   assign is_stex  = req_valid_i && (req_op_i == OP_STEX);
   assign is_store = req_valid_i && (req_op_i == OP_STORE);
   assign is_clear = req_valid_i && (req_op_i == OP_CLEAR);

   logic          resv_valid, snoop_hit_old;
   logic [AW-1:0] resv_addr;
   logic [1:0]    resv_size;
   logic          snoop_on_new, store_on_resv;
   logic          set_resv, drop_resv, stex_pass;

   exmon_gran_cmp #(.AW(AW), .GRAN_LOG2(GRAN_LOG2)) u_new_cmp (
      .a_i (snoop_addr_i),
      .b_i (eff),
      .eq_o(snoop_on_new)
   );

   exmon_gran_cmp #(.AW(AW), .GRAN_LOG2(GRAN_LOG2)) u_store_cmp (
      .a_i (eff),
      .b_i (resv_addr),
      .eq_o(store_on_resv)
   );

   assign set_resv  = is_ldex && legal && !(snoop_valid_i && snoop_on_new);
   assign drop_resv = is_stex || is_clear || (is_ldex && !set_resv)
                    || (is_store && legal && store_on_resv);

   exmon_resv #(.AW(AW), .GRAN_LOG2(GRAN_LOG2)) u_resv (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .set_i        (set_resv),
      .set_addr_i   (eff),
      .set_size_i   (req_size_i),
      .drop_i       (drop_resv),
      .snoop_valid_i(snoop_valid_i),
      .snoop_addr_i (snoop_addr_i),
      .valid_o      (resv_valid),
      .addr_o       (resv_addr),
      .size_o       (resv_size),
      .snoop_hit_o  (snoop_hit_old)
   );

   assign stex_pass = is_stex && legal && resv_valid && !snoop_hit_old
                    && (resv_addr == eff) && (resv_size == req_size_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_done_o  <= 1'b0;
         st_fail_o  <= 1'b0;
         mem_we_o   <= 1'b0;
         mem_addr_o <= '0;
         mem_size_o <= '0;
         illegal_o  <= 1'b0;
      end else begin
         st_done_o  <= is_stex;
         st_fail_o  <= is_stex && !stex_pass;
         mem_we_o   <= stex_pass || (is_store && legal);
         mem_addr_o <= eff;
         mem_size_o <= req_size_i;
         illegal_o  <= req_valid_i && !is_clear && !legal;
      end
   end

   a_r4_fail_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_done_o && st_fail_o) |-> !mem_we_o);
   a_r4_no_resv_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_stex && !resv_valid) |=> (st_done_o && st_fail_o));
   a_r10_illegal_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |-> !mem_we_o);
   a_r11_fail_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_fail_o |-> st_done_o);
endmodule

// File: tb/excl_monitor_tb_top.sv
module excl_monitor_tb_top;
   localparam int AW = 32;
   localparam int OW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rv = 1'b0;
   logic [1:0]    op = '0;
   logic [AW-1:0] base = '0;
   logic [OW-1:0] off = '0;
   logic [1:0]    sz = '0;
   logic          sv = 1'b0;
   logic [AW-1:0] sa = '0;
   logic          done, fail, we, ill;
   logic [AW-1:0] maddr;
   logic [1:0]    msize;

   int errors = 0;
   int checks = 0;
   logic          g_done, g_fail, g_we, g_ill;
   logic [AW-1:0] g_addr;
   logic [1:0]    g_size;

   always #5 clk = ~clk;

   excl_monitor dut_i (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv), .req_op_i(op),
      .req_base_i(base), .req_offset_i(off), .req_size_i(sz),
      .snoop_valid_i(sv), .snoop_addr_i(sa),
      .st_done_o(done), .st_fail_o(fail), .mem_we_o(we),
      .mem_addr_o(maddr), .mem_size_o(msize), .illegal_o(ill)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   // Drive at negedge, let the posedge register, capture 1 ns later.
   task automatic issue(input logic v, input logic [1:0] o, input logic [AW-1:0] b,
                        input logic [OW-1:0] f, input logic [1:0] s,
                        input logic snv, input logic [AW-1:0] sna);
      rv = v; op = o; base = b; off = f; sz = s; sv = snv; sa = sna;
      @(posedge clk); #1;
      g_done = done; g_fail = fail; g_we = we; g_ill = ill; g_addr = maddr; g_size = msize;
      @(negedge clk);
      rv = 1'b0; sv = 1'b0;
   endtask

   task automatic ldex(input logic [AW-1:0] b, input logic [OW-1:0] f, input logic [1:0] s);
      issue(1'b1, 2'd0, b, f, s, 1'b0, '0);
   endtask

   task automatic stex_exp(input string tag, input logic [AW-1:0] b, input logic [OW-1:0] f,
                           input logic [1:0] s, input logic pass);
      issue(1'b1, 2'd1, b, f, s, 1'b0, '0);
      chk({tag, " done"}, 32'(g_done), 32'd1);
      chk({tag, " fail"}, 32'(g_fail), 32'(!pass));
      chk({tag, " we"},   32'(g_we),   32'(pass));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 done", 32'(done), 0); chk("R9 fail", 32'(fail), 0);
      chk("R9 we", 32'(we), 0);     chk("R9 ill", 32'(ill), 0);
      chk("R9 addr", maddr, 0);
      rst_n = 1'b1;
      @(negedge clk);
      stex_exp("R9 stex after reset", 32'h100, 0, 2'd2, 1'b0);

      // R3/R2: basic word pass with offset
      ldex(32'h2000, 11'd8, 2'd2);
      chk("R2 ldex addr", g_addr, 32'h2008);
      chk("R11 ldex no done", 32'(g_done), 0);
      stex_exp("R3 word pass", 32'h2000, 11'd8, 2'd2, 1'b1);
      chk("R2 stex addr", g_addr, 32'h2008);
      chk("R2 stex size", 32'(g_size), 2);

      // R10/R2: offset sweep over all OW-bit values
      for (int o = 0; o < 2048; o++) begin
         bit good;
         good = (o % 4 == 0) && (o <= 1020);
         ldex(32'h1000, 11'(o), 2'd2);
         chk("R10 ldex illegal", 32'(g_ill), 32'(!good));
         issue(1'b1, 2'd1, 32'h1000, 11'(o), 2'd2, 1'b0, '0);
         chk("R10 stex illegal", 32'(g_ill), 32'(!good));
         chk("R10 stex fail", 32'(g_fail), 32'(!good));
         chk("R10 stex we", 32'(g_we), 32'(good));
         if (good) chk("R2 sweep addr", g_addr, 32'h1000 + 32'(o));
      end

      // R1/R3/R4: size matrix
      for (int a = 0; a < 3; a++) begin
         for (int b = 0; b < 3; b++) begin
            ldex(32'h300, 0, 2'(a));
            stex_exp("R1 R4 size match", 32'h300, 0, 2'(b), a == b);
         end
      end

      // R2: offset ignored for byte and halfword
      ldex(32'h141, 11'd8, 2'd0);
      chk("R2 byte addr", g_addr, 32'h141);
      stex_exp("R2 byte offset ignored", 32'h141, 11'd0, 2'd0, 1'b1);
      ldex(32'h142, 11'd3, 2'd1);
      chk("R10 half odd offset legal", 32'(g_ill), 0);
      stex_exp("R2 half offset ignored", 32'h142, 11'd100, 2'd1, 1'b1);

      // R4: address mismatch
      ldex(32'h400, 0, 2'd2);
      stex_exp("R4 addr mismatch", 32'h404, 0, 2'd2, 1'b0);

      // R5: snoop sweep in idle cycle, same cycle as STEX, same cycle as LDEX
      for (int d = -8; d <= 8; d++) begin
         logic [AW-1:0] s_a;
         bit hit;
         s_a = 32'h200 + 32'(d);
         hit = (s_a >> 2) == (32'h200 >> 2);
         ldex(32'h200, 0, 2'd2);
         issue(1'b0, 2'd0, '0, '0, '0, 1'b1, s_a);
         stex_exp("R5 idle snoop", 32'h200, 0, 2'd2, !hit);
         ldex(32'h200, 0, 2'd2);
         issue(1'b1, 2'd1, 32'h200, 0, 2'd2, 1'b1, s_a);
         chk("R5 snoop with stex", 32'(g_fail), 32'(hit));
         issue(1'b1, 2'd0, 32'h200, 0, 2'd2, 1'b1, s_a);
         stex_exp("R5 snoop with ldex", 32'h200, 0, 2'd2, !hit);
      end

      // R6: ordinary store
      ldex(32'h500, 0, 2'd2);
      issue(1'b1, 2'd2, 32'h600, 0, 2'd2, 1'b0, '0);
      chk("R6 store we", 32'(g_we), 1);
      chk("R6 store no done", 32'(g_done), 0);
      stex_exp("R6 store elsewhere keeps", 32'h500, 0, 2'd2, 1'b1);
      ldex(32'h500, 0, 2'd2);
      issue(1'b1, 2'd2, 32'h502, 0, 2'd0, 1'b0, '0);
      stex_exp("R6 store same granule", 32'h500, 0, 2'd2, 1'b0);

      // R7: stex clears, ldex replaces
      ldex(32'h700, 0, 2'd2);
      stex_exp("R7 first", 32'h700, 0, 2'd2, 1'b1);
      stex_exp("R7 second fails", 32'h700, 0, 2'd2, 1'b0);
      ldex(32'h700, 0, 2'd2);
      stex_exp("R7 failing stex", 32'h704, 0, 2'd2, 1'b0);
      stex_exp("R7 after fail", 32'h700, 0, 2'd2, 1'b0);
      ldex(32'h700, 0, 2'd2); ldex(32'h800, 0, 2'd2);
      stex_exp("R7 old replaced", 32'h700, 0, 2'd2, 1'b0);
      ldex(32'h700, 0, 2'd2); ldex(32'h800, 0, 2'd2);
      stex_exp("R7 new holds", 32'h800, 0, 2'd2, 1'b1);

      // R8: clear
      ldex(32'h900, 0, 2'd2);
      issue(1'b1, 2'd3, '0, '0, '0, 1'b0, '0);
      chk("R8 clear no ill", 32'(g_ill), 0);
      chk("R11 clear no done", 32'(g_done), 0);
      stex_exp("R8 after clear", 32'h900, 0, 2'd2, 1'b0);

      // R10: bad size code, illegal ldex drops
      ldex(32'hA00, 0, 2'd2);
      ldex(32'hA00, 0, 2'd3);
      chk("R10 size3 illegal", 32'(g_ill), 1);
      stex_exp("R10 illegal ldex drops", 32'hA00, 0, 2'd2, 1'b0);
      issue(1'b1, 2'd2, 32'hB00, 11'd2, 2'd2, 1'b0, '0);
      chk("R10 bad store no write", 32'(g_we), 0);
      chk("R10 bad store illegal", 32'(g_ill), 1);

      // R11: idle cycle after stex
      issue(1'b0, 2'd1, '0, '0, '0, 1'b0, '0);
      chk("R11 idle done", 32'(g_done), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule